// File: doc/BRIEF.md
# Single-Pixel Frame Grabber Port

This block lets a host pull a complete sensor image out through one byte-wide register, one pixel per frame. The imager streams every pixel of every frame together with its index. The block keeps a target index and watches that stream. Once it is armed, it takes the pixel whose index matches the target from the next frame that begins. It then holds that pixel until the host reads it.

Any access to the register arms the grabber. A write also points the target back at the first pixel of the image. A read that finds a held pixel returns it, moves the target on by one and re-arms, so a full image takes at least one frame per pixel.

The returned byte has three parts:
- bit 7 marks the first pixel of the image;
- bit 6 marks that a pixel is held;
- the low bits carry the pixel value.

Address decoding lies outside the block. It sees only read and write strobes that are already qualified for this register.

Top module: `pixgrab_port`

## Requirements
- R1: After reset the byte reads 0x00, the target is the first pixel, and the grabber is not armed, so frames passing with no access capture nothing.
- R2: The byte is {first-pixel flag in bit 7, valid flag in bit 6, pixel value in bits 5..0}; the first-pixel flag is 1 exactly when the held pixel has stream index 0; whenever the valid flag is 0 the whole byte is 0x00.
- R3: A write moves the target to stream index 0, clears any held pixel and arms; the next pixel returned carries the first-pixel flag.
- R4: An arming access waits for a frame-start tick in a later cycle: a tick in the same cycle as the arming access does not count, and no pixel is taken before the following tick.
- R5: In the armed frame, the stream pixel whose index equals the target is latched, and the byte shows it with the valid flag from the next cycle on.
- R6: A held pixel stays unchanged on the byte across any number of frames until it is read.
- R7: A read that finds the valid flag set returns the held pixel, clears the flag, moves the target to the next index and re-arms.
- R8: The target wraps from index NUM_PIX-1 (324th pixel) to index 0, so the 325th returned pixel after a write carries the first-pixel flag again.
- R9: A read that finds the valid flag clear returns 0x00, does not move the target and does not disturb a capture already armed or in progress.
- R10: A write in the same cycle as the stream delivers the target pixel wins: nothing is latched and the grabber waits for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | One-cycle tick before the pixels of a frame |
| pix_valid | input | 1 | Stream carries a pixel this cycle |
| pix_index | input | 9 | Index of the stream pixel, 0 to NUM_PIX-1 |
| pix_data | input | 6 | Value of the stream pixel |
| reg_wr | input | 1 | Write strobe for the pixel register |
| reg_rd | input | 1 | Read strobe for the pixel register; the byte is sampled in the same cycle |
| reg_rdata | output | 8 | Returned byte: first-pixel flag, valid flag, pixel value |

## Verification
Two functions can fall in one cycle: the capture of the target pixel from the stream, and a host access to the register. The bench keeps a running stream position, so it can put a write or a read on exactly the cycle where the stream delivers the target index.

For a colliding write, the bench expects nothing to be latched. A later read must then return the same pixel from the following frame. For a colliding read while the valid flag is clear, the read must return 0x00 and the capture must still land, which the bench judges from the very next read.

// File: rtl/pixgrab_pkg.sv
package pixgrab_pkg;

    // Arming sequence of the grabber. HOLD means a pixel is available.
    typedef enum logic [1:0] {
        GRAB_IDLE     = 2'd0,
        GRAB_WAIT_SOF = 2'd1,
        GRAB_SCAN     = 2'd2,
        GRAB_HOLD     = 2'd3
    } grab_state_e;

endpackage

// File: rtl/pixgrab_index.sv
module pixgrab_index #(
    parameter int  NUM_PIX = 324,
    localparam int IDX_W   = $clog2(NUM_PIX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             advance_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             first_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PIX - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } idx_regs_t;

    idx_regs_t q, d;

    always_comb begin
        d = q;
        if (clear_i) begin
            d.idx = '0;
        end else if (advance_i) begin
            if (q.idx == LAST_IDX) d.idx = '0;
            else                   d.idx = q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign idx_o   = q.idx;
    assign first_o = (q.idx == '0);

    // R8: target index never leaves the frame
    assert_idx_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.idx <= LAST_IDX);

    // R8: advancing from the last pixel returns to index 0
    assert_idx_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !clear_i && q.idx == LAST_IDX) |=> (q.idx == '0));

    // R3: a clear always lands on index 0
    assert_idx_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (q.idx == '0));

    // R9: index moves only when told to
    assert_idx_still_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !advance_i) |=> $stable(q.idx));

endmodule

// File: rtl/pixgrab_capture.sv
module pixgrab_capture #(
    parameter int  NUM_PIX = 324,
    parameter int  PIX_W   = 6,
    localparam int IDX_W   = $clog2(NUM_PIX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid_i,
    input  logic [IDX_W-1:0] pix_index_i,
    input  logic [PIX_W-1:0] pix_data_i,
    input  logic [IDX_W-1:0] target_i,
    input  logic             load_i,
    output logic             hit_o,
    output logic [PIX_W-1:0] pix_o
);

    typedef struct packed {
        logic [PIX_W-1:0] pix;
    } cap_regs_t;

    cap_regs_t q, d;

    assign hit_o = pix_valid_i && (pix_index_i == target_i);

    always_comb begin
        d = q;
        if (load_i) d.pix = pix_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pix_o = q.pix;

    // R5: a load takes the stream value of that cycle
    assert_cap_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (q.pix == $past(pix_data_i)));

    // R6: without a load the held value does not move
    assert_cap_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(q.pix));

endmodule

// File: rtl/pixgrab_fsm.sv
module pixgrab_fsm
    import pixgrab_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic        rd_i,
    input  logic        frame_start_i,
    input  logic        hit_i,
    output grab_state_e state_o,
    output logic        load_o,
    output logic        advance_o
);

    typedef struct packed {
        grab_state_e state;
    } fsm_regs_t;

    fsm_regs_t q, d;

    always_comb begin
        d         = q;
        load_o    = 1'b0;
        advance_o = 1'b0;
        if (wr_i) begin
            d.state = GRAB_WAIT_SOF;
        end else begin
            unique case (q.state)
                GRAB_IDLE: begin
                    if (rd_i) d.state = GRAB_WAIT_SOF;
                end
                GRAB_WAIT_SOF: begin
                    if (frame_start_i) d.state = GRAB_SCAN;
                end
                GRAB_SCAN: begin
                    if (hit_i) begin
                        load_o  = 1'b1;
                        d.state = GRAB_HOLD;
                    end
                end
                GRAB_HOLD: begin
                    if (rd_i) begin
                        advance_o = 1'b1;
                        d.state   = GRAB_WAIT_SOF;
                    end
                end
                default: d.state = GRAB_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q.state <= GRAB_IDLE;
        else        q       <= d;
    end

    assign state_o = q.state;

    // R4: a waiting grabber needs a frame start before it can hold a pixel
    assert_no_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == GRAB_WAIT_SOF) |=> (q.state != GRAB_HOLD));

    // R1: without access an idle grabber stays idle
    assert_idle_stays_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == GRAB_IDLE && !rd_i && !wr_i) |=> (q.state == GRAB_IDLE));

    // R10: a write always re-arms for a fresh frame
    assert_wr_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (q.state == GRAB_WAIT_SOF));

    // R6: a held pixel is kept while nobody touches the register
    assert_hold_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == GRAB_HOLD && !rd_i && !wr_i) |=> (q.state == GRAB_HOLD));

endmodule

// File: rtl/pixgrab_port.sv
module pixgrab_port
    import pixgrab_pkg::*;
#(
    parameter int  NUM_PIX = 324,
    parameter int  PIX_W   = 6,
    localparam int IDX_W   = $clog2(NUM_PIX),
    localparam int BYTE_W  = PIX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              pix_valid,
    input  logic [IDX_W-1:0]  pix_index,
    input  logic [PIX_W-1:0]  pix_data,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [BYTE_W-1:0] reg_rdata
);

    grab_state_e      state;
    logic             load;
    logic             advance;
    logic             hit;
    logic [IDX_W-1:0] target;
    logic             first;
    logic [PIX_W-1:0] held_pix;
    logic             valid;

    pixgrab_fsm i_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_i          (reg_wr),
        .rd_i          (reg_rd),
        .frame_start_i (frame_start),
        .hit_i         (hit),
        .state_o       (state),
        .load_o        (load),
        .advance_o     (advance)
    );

    pixgrab_index #(.NUM_PIX(NUM_PIX)) i_index (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (reg_wr),
        .advance_i (advance),
        .idx_o     (target),
        .first_o   (first)
    );

    pixgrab_capture #(.NUM_PIX(NUM_PIX), .PIX_W(PIX_W)) i_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_valid_i (pix_valid),
        .pix_index_i (pix_index),
        .pix_data_i  (pix_data),
        .target_i    (target),
        .load_i      (load),
        .hit_o       (hit),
        .pix_o       (held_pix)
    );

    assign valid = (state == GRAB_HOLD);

    always_comb begin
        if (valid) reg_rdata = {first, 1'b1, held_pix};
        else       reg_rdata = '0;
    end

    // R2: a byte without the valid flag is entirely zero
    assert_empty_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[PIX_W] |-> (reg_rdata == '0));

    // R3: after a write the byte reads empty
    assert_wr_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_rdata == '0));

    // R7: a consuming read clears the valid flag
    assert_rd_consumes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_rdata[PIX_W]) |=> !reg_rdata[PIX_W]);

    // R6: an untouched held byte stays the same
    assert_byte_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[PIX_W] && !reg_rd && !reg_wr) |=> $stable(reg_rdata));

endmodule

// File: tb/test_pixgrab_port.sv
`timescale 1ns/1ps
module test_pixgrab_port;

    localparam int NUM_PIX = 324;
    localparam int PIX_W   = 6;
    localparam int FL      = NUM_PIX + 6;   // stream cycles per frame

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       pix_valid = 1'b0;
    logic [8:0] pix_index = '0;
    logic [5:0] pix_data = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_rdata;

    pixgrab_port #(.NUM_PIX(NUM_PIX), .PIX_W(PIX_W)) i_pixgrab_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .pix_valid   (pix_valid),
        .pix_index   (pix_index),
        .pix_data    (pix_data),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_rdata   (reg_rdata)
    );

    always #4 clk = ~clk;   // 125 MHz

    int         n_checks = 0;
    int         n_err    = 0;
    int         pos      = 0;
    string      cur_tag  = "R1";
    logic [7:0] last_byte;

    // reference state kept from the requirements
    int         m_st  = 0;      // 0 idle, 1 wait frame, 2 scanning, 3 holding
    int         m_idx = 0;
    logic [5:0] m_pix = '0;

    function automatic logic [5:0] pixf(int idx, int frame);
        return 6'((idx * 5 + frame * 11 + 3) % 64);
    endfunction

    function automatic logic [7:0] exp_byte();
        if (m_st == 3) return {(m_idx == 0), 1'b1, m_pix};
        return 8'h00;
    endfunction

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    task automatic step(input logic wr, input logic rd);
        int p;
        logic sof, pv, hit;
        int sidx;
        logic [5:0] sdat;
        @(negedge clk);
        p    = pos % FL;
        sof  = (p == 0);
        pv   = (p >= 1) && (p <= NUM_PIX);
        sidx = pv ? p - 1 : 0;
        sdat = pixf(sidx, pos / FL);
        frame_start = sof;
        pix_valid   = pv;
        pix_index   = 9'(sidx);
        pix_data    = sdat;
        reg_wr      = wr;
        reg_rd      = rd;
        #1;
        last_byte = reg_rdata;
        if (rd) check(cur_tag, reg_rdata, exp_byte());
        hit = pv && (sidx == m_idx);
        if (wr) begin
            m_idx = 0;
            m_st  = 1;
        end else begin
            case (m_st)
                0: if (rd) m_st = 1;
                1: if (sof) m_st = 2;
                2: if (hit) begin m_pix = sdat; m_st = 3; end
                default: if (rd) begin
                    m_idx = (m_idx + 1) % NUM_PIX;
                    m_st  = 1;
                end
            endcase
        end
        pos++;
    endtask

    task automatic idle_to(int phase);
        while ((pos % FL) != phase) step(1'b0, 1'b0);
    endtask

    task automatic wait_hold();
        while (m_st != 3) step(1'b0, 1'b0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL R7: got watchdog timeout expected run completion");
        summary();
        $finish;
    end

    initial begin
        int f;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, then two frames without any access
        cur_tag = "R1";
        step(1'b0, 1'b0);
        check("R1", last_byte, 8'h00);
        repeat (2 * FL) step(1'b0, 1'b0);
        check("R1", last_byte, 8'h00);

        // R3/R2: write mid-frame, then first pixel of the next frame
        cur_tag = "R3";
        idle_to(50);
        step(1'b1, 1'b0);
        cur_tag = "R9";
        step(1'b0, 1'b1);
        f = pos / FL + 1;
        cur_tag = "R3";
        wait_hold();
        step(1'b0, 1'b1);
        check("R2", last_byte, {1'b1, 1'b1, pixf(0, f)});

        // R4: write on the frame-start cycle itself
        cur_tag = "R4";
        idle_to(0);
        f = pos / FL;
        step(1'b1, 1'b0);
        idle_to(FL - 1);
        step(1'b0, 1'b1);
        check("R4", last_byte, 8'h00);
        wait_hold();
        step(1'b0, 1'b1);
        check("R4", last_byte, {1'b1, 1'b1, pixf(0, f + 1)});

        // R4: one pixel per frame, read right after capture, index 2 follows
        cur_tag = "R5";
        wait_hold();
        f = pos / FL;
        step(1'b0, 1'b1);
        check("R5", last_byte, {1'b0, 1'b1, pixf(1, f)});
        cur_tag = "R4";
        idle_to(FL - 1);
        step(1'b0, 1'b1);
        check("R4", last_byte, 8'h00);

        // R9: read with flag clear in the very cycle of the capture
        cur_tag = "R9";
        idle_to(0);
        step(1'b0, 1'b0);
        f = pos / FL;
        idle_to(1 + m_idx);
        step(1'b0, 1'b1);
        check("R9", last_byte, 8'h00);
        cur_tag = "R7";
        step(1'b0, 1'b1);
        check("R9", last_byte, {1'b0, 1'b1, pixf(2, f)});

        // R6: held across several frames
        cur_tag = "R6";
        wait_hold();
        f = pos / FL;
        repeat (3 * FL) step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        check("R6", last_byte, {1'b0, 1'b1, pixf(3, f)});

        // R10: write collides with capture of the target pixel
        cur_tag = "R10";
        step(1'b1, 1'b0);
        idle_to(0);
        step(1'b0, 1'b0);
        f = pos / FL;
        step(1'b1, 1'b0);
        idle_to(FL - 1);
        step(1'b0, 1'b1);
        check("R10", last_byte, 8'h00);
        wait_hold();
        step(1'b0, 1'b1);
        check("R10", last_byte, {1'b1, 1'b1, pixf(0, f + 1)});

        // R8: full image plus one, starting from a write
        cur_tag = "R8";
        step(1'b1, 1'b0);
        for (int k = 1; k <= NUM_PIX + 1; k++) begin
            wait_hold();
            step(1'b0, 1'b1);
            if (k == 1)       check("R8", {7'h0, last_byte[7]}, 8'h01);
            if (k == NUM_PIX) check("R8", {7'h0, last_byte[7]}, 8'h00);
            if (k == NUM_PIX + 1) check("R8", {7'h0, last_byte[7]}, 8'h01);
        end

        // R7: random accesses against the reference
        cur_tag = "R7";
        void'($urandom(32'd2024));
        for (int c = 0; c < 20000; c++) begin
            logic w, r;
            w = ($urandom % 400) == 0;
            r = ($urandom % 40) == 0;
            step(w, r);
        end

        summary();
        $finish;
    end

endmodule